// File: doc/BRIEF.md
# Cipher Unit Error Status Logic

This block watches the register traffic of a DES / triple-DES execution unit and records configuration and access mistakes in a sticky 64-bit status word. It checks the odd parity of every key byte. Which key registers it checks depends on the current mode and key size. It also rejects key sizes that the cipher cannot use. It flags IV reads and any context register writes made while the datapath is busy. A host-written control word masks each error bit individually. Writing one to a control bit also clears the matching status bit.

Any non-zero status stops the cipher core through a halt request and raises an error interrupt, one cycle after the status changes. The data bus, the cipher datapath and the interrupt routing stay outside. The block only sees strobes, the shared write data, the current mode and key size values, the busy flag and an internal-fault input.

Top module: `des_err_status`

## Requirements
- R1: A write to key register 1 (`key_wr[0]`) whose data holds any byte with even parity (odd parity means the XOR of the 8 bits of a byte is 1) sets the key parity bit, status bit 50, in every mode.
- R2: A bad-parity write to key register 2 (`key_wr[1]`) sets bit 50 only when `cur_tdes` is 1 and `cur_ksize` is 16 or 24. A bad-parity write to key register 3 (`key_wr[2]`) sets bit 50 only when `cur_tdes` is 1 and `cur_ksize` is 24. Otherwise such a write leaves bit 50 unchanged.
- R3: A key size write (`ksize_wr`) sets the key size bit, status bit 54, when `wr_data[7:0]` is not 8, 16 or 24. The values 8, 16 and 24 set nothing.
- R4: `iv_rd` while `busy` is 1 sets the early read bit, status bit 52. The same read while idle sets nothing.
- R5: While `busy` is 1, any of `key_wr`, `ksize_wr`, `dsize_wr`, `mode_wr` or `iv_wr` sets the context bit, status bit 53.
- R6: A status bit at positions 50..54 cannot be set while its control bit is 1. The control bit in force is `ctrl_wdata` at the same index in a cycle with `ctrl_wr`, and otherwise the last value written.
- R7: The internal error bit, status bit 51, is set by `int_fault` or by any error among bits 50, 52, 53, 54 that is not masked, provided bit 51 itself is not masked.
- R8: Status bits are sticky. A status bit clears only in a cycle with `ctrl_wr` and a 1 at the same index of `ctrl_wdata`, or through reset. Reset also clears every control bit.
- R9: `halt` and `err_irq` are 1 in the cycle after one in which the status word is non-zero, and 0 in the cycle after one in which it is zero.
- R10: The status word is numbered with bit 0 as the MSB. Bits 0..49 and 55..63 always read 0.
- R11: Each error is recorded at the rising edge that samples the offending strobe. Several errors in one cycle all set their bits at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Cipher datapath is processing |
| cur_tdes | input | 1 | Current mode selects triple DES |
| cur_ksize | input | 8 | Current key size register value, in bytes |
| wr_data | input | 64 | Shared register write data |
| key_wr | input | 3 | Key register write strobes; bit 0 is key register 1 |
| ksize_wr | input | 1 | Key size register write strobe |
| dsize_wr | input | 1 | Data size register write strobe |
| mode_wr | input | 1 | Mode register write strobe |
| iv_wr | input | 1 | IV register write strobe |
| iv_rd | input | 1 | IV register read strobe |
| int_fault | input | 1 | Internal processing fault from the datapath |
| ctrl_wr | input | 1 | Control (mask/clear) register write strobe |
| ctrl_wdata | input | 64 | Control write value, indexed [0:63] with bit 0 as MSB |
| status | output | 64 | Error status word, indexed [0:63] with bit 0 as MSB |
| halt | output | 1 | Stop request to the cipher core |
| err_irq | output | 1 | Error interrupt |

## Verification
A wrong sticky or mask flop shows up at `status` at the first edge after the stimulus. Examples are a bit that drops without a clear, or a bit that sets through a mask. A corrupted control register stays hidden until an error of that type occurs, so the random phase keeps mixing masks with every strobe kind. A fault in the halt path shows at `halt` and `err_irq` one cycle after the status word changes. Each cycle, the bench compares the whole 64-bit word, which exposes stray bits in the reserved ranges at once.

// File: rtl/des_err_pkg.sv
package des_err_pkg;
  localparam int STAT_W    = 64;
  localparam int ERR_N     = 5;
  localparam int FIRST_BIT = 50;
  localparam int TAIL_W    = STAT_W - FIRST_BIT - ERR_N;
  // error vector index, MSB lands on status bit FIRST_BIT
  localparam int I_KPE = 4;
  localparam int I_IE  = 3;
  localparam int I_ERE = 2;
  localparam int I_CE  = 1;
  localparam int I_KSE = 0;
  localparam logic [ERR_N-1:0] CAUSE_MASK = 5'b10111;
endpackage

// File: rtl/key_parity_chk.sv
module key_parity_chk #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data,
  output logic              all_odd
);
  localparam int BYTES = DATA_W / 8;
  logic [BYTES-1:0] byte_ok;

  genvar gi;
  generate
    for (gi = 0; gi < BYTES; gi++) begin : g_byte
      assign byte_ok[gi] = ^data[8*gi +: 8];
    end
  endgenerate

  assign all_odd = &byte_ok;
endmodule

// File: rtl/des_err_detect.sv
module des_err_detect
  import des_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int KEY_REGS = 3,
  parameter int SZ_W     = 8
) (
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [KEY_REGS-1:0] key_wr,
  input  logic                ksize_wr,
  input  logic                dsize_wr,
  input  logic                mode_wr,
  input  logic                iv_wr,
  input  logic                iv_rd,
  input  logic                busy,
  input  logic                cur_tdes,
  input  logic [SZ_W-1:0]     cur_ksize,
  input  logic                int_fault,
  output logic [ERR_N-1:0]    det
);
  localparam logic [SZ_W-1:0] SZ_SINGLE = SZ_W'(8);
  localparam logic [SZ_W-1:0] SZ_MIN3   = SZ_W'(16);
  localparam logic [SZ_W-1:0] SZ_MAX3   = SZ_W'(8 * KEY_REGS);

  logic                parity_ok;
  logic [KEY_REGS-1:0] key_chk_en;
  logic                cur_sz_multi;
  logic [SZ_W-1:0]     new_size;
  logic                new_size_ok;
  logic                any_ctx_wr;

  key_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data    (wr_data),
    .all_odd (parity_ok)
  );

  // multi-key sizes: multiples of 8 from 16 up to 8 per key register
  assign cur_sz_multi = (cur_ksize[2:0] == 3'b000) &&
                        (cur_ksize >= SZ_MIN3) && (cur_ksize <= SZ_MAX3);

  genvar gk;
  generate
    for (gk = 0; gk < KEY_REGS; gk++) begin : g_key_en
      if (gk == 0) begin : g_first
        assign key_chk_en[gk] = 1'b1;
      end else begin : g_later
        assign key_chk_en[gk] = cur_tdes && cur_sz_multi &&
                                (cur_ksize >= SZ_W'(8 * (gk + 1)));
      end
    end
  endgenerate

  assign new_size    = wr_data[SZ_W-1:0];
  assign new_size_ok = (new_size == SZ_SINGLE) ||
                       ((new_size[2:0] == 3'b000) &&
                        (new_size >= SZ_MIN3) && (new_size <= SZ_MAX3));

  assign any_ctx_wr = (|key_wr) | ksize_wr | dsize_wr | mode_wr | iv_wr;

  always_comb begin
    det        = '0;
    det[I_KPE] = !parity_ok && |(key_wr & key_chk_en);
    det[I_KSE] = ksize_wr && !new_size_ok;
    det[I_ERE] = busy && iv_rd;
    det[I_CE]  = busy && any_ctx_wr;
    det[I_IE]  = int_fault;
  end
endmodule

// File: rtl/des_err_regs.sv
module des_err_regs
  import des_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] det,
  input  logic             ctrl_wr,
  input  logic [ERR_N-1:0] ctrl_bits,
  output logic [ERR_N-1:0] st_q,
  output logic [ERR_N-1:0] mask_q,
  output logic             halt_q
);
  logic [ERR_N-1:0] mask_eff;
  logic [ERR_N-1:0] clr;
  logic [ERR_N-1:0] raw;
  logic [ERR_N-1:0] st_n;
  logic [ERR_N-1:0] mask_n;
  logic             mask_en;
  logic             halt_n;

  always_comb begin
    mask_en   = ctrl_wr;
    mask_n    = ctrl_bits;
    mask_eff  = mask_en ? mask_n : mask_q;
    clr       = mask_en ? ctrl_bits : '0;
    raw       = det;
    raw[I_IE] = det[I_IE] | (|(det & CAUSE_MASK & ~mask_eff));
    st_n      = (st_q & ~clr) | (raw & ~mask_eff);
    halt_n    = |st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      halt_q <= halt_n;
      if (mask_en) mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/des_err_status.sv
module des_err_status
  import des_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int KEY_REGS = 3,
  parameter int SZ_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                cur_tdes,
  input  logic [SZ_W-1:0]     cur_ksize,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [KEY_REGS-1:0] key_wr,
  input  logic                ksize_wr,
  input  logic                dsize_wr,
  input  logic                mode_wr,
  input  logic                iv_wr,
  input  logic                iv_rd,
  input  logic                int_fault,
  input  logic                ctrl_wr,
  input  logic [0:STAT_W-1]   ctrl_wdata,
  output logic [0:STAT_W-1]   status,
  output logic                halt,
  output logic                err_irq
);
  logic [ERR_N-1:0] det;
  logic [ERR_N-1:0] st_q;
  logic [ERR_N-1:0] mask_q;
  logic             halt_q;
  logic [ERR_N-1:0] ctrl_bits;
  logic             unused_ctrl;

  assign ctrl_bits   = ctrl_wdata[FIRST_BIT +: ERR_N];
  assign unused_ctrl = ^{ctrl_wdata[0:FIRST_BIT-1], ctrl_wdata[FIRST_BIT+ERR_N:STAT_W-1]};

  des_err_detect #(
    .DATA_W   (DATA_W),
    .KEY_REGS (KEY_REGS),
    .SZ_W     (SZ_W)
  ) u_detect (
    .wr_data   (wr_data),
    .key_wr    (key_wr),
    .ksize_wr  (ksize_wr),
    .dsize_wr  (dsize_wr),
    .mode_wr   (mode_wr),
    .iv_wr     (iv_wr),
    .iv_rd     (iv_rd),
    .busy      (busy),
    .cur_tdes  (cur_tdes),
    .cur_ksize (cur_ksize),
    .int_fault (int_fault),
    .det       (det)
  );

  des_err_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .det       (det),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (ctrl_bits),
    .st_q      (st_q),
    .mask_q    (mask_q),
    .halt_q    (halt_q)
  );

  assign status  = {{FIRST_BIT{1'b0}}, st_q, {TAIL_W{1'b0}}};
  assign halt    = halt_q;
  assign err_irq = halt_q;
endmodule

// File: rtl/des_err_status_chk.sv
module des_err_status_chk
  import des_err_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mode_wr,
  input logic              iv_rd,
  input logic              ctrl_wr,
  input logic [0:STAT_W-1] ctrl_wdata,
  input logic [0:STAT_W-1] status,
  input logic [ERR_N-1:0]  mask_q,
  input logic              halt
);
  genvar gj;
  generate
    for (gj = FIRST_BIT; gj < FIRST_BIT + ERR_N; gj++) begin : g_bit
      // R6: a masked, clear bit stays clear
      a_r6_masked_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[gj] && mask_q[FIRST_BIT + ERR_N - 1 - gj] && !ctrl_wr) |=> !status[gj]);
      // R8: a set bit holds unless cleared
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[gj] && !(ctrl_wr && ctrl_wdata[gj])) |=> status[gj]);
      // R8: writing one to the control bit clears it
      a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[gj]) |=> !status[gj]);
    end
  endgenerate

  a_r9_halt_on: assert property (@(posedge clk) disable iff (!rst_n)
    (|status) |=> halt);
  a_r9_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(|status) |=> !halt);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0:FIRST_BIT-1] == '0) && (status[FIRST_BIT+ERR_N:STAT_W-1] == '0));
  a_r4_early_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iv_rd && !ctrl_wr && !mask_q[I_ERE]) |=> status[FIRST_BIT + ERR_N - 1 - I_ERE]);
  a_r5_context: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_wr && !ctrl_wr && !mask_q[I_CE]) |=> status[FIRST_BIT + ERR_N - 1 - I_CE]);
endmodule

bind des_err_status des_err_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mode_wr    (mode_wr),
  .iv_rd      (iv_rd),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .status     (status),
  .mask_q     (mask_q),
  .halt       (halt)
);

// File: tb/tb_des_err_status.sv
module tb_des_err_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        busy, cur_tdes;
  logic [7:0]  cur_ksize;
  logic [63:0] wr_data;
  logic [2:0]  key_wr;
  logic        ksize_wr, dsize_wr, mode_wr, iv_wr, iv_rd, int_fault, ctrl_wr;
  logic [0:63] ctrl_wdata;
  logic [0:63] status;
  logic        halt, err_irq;

  int total = 0;
  int bad   = 0;
  logic [4:0] exp_st;    // [4]=parity,[3]=internal,[2]=early read,[1]=context,[0]=size
  logic [4:0] exp_mask;
  logic       exp_halt;

  always #2 clk = ~clk;

  des_err_status dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cur_tdes(cur_tdes), .cur_ksize(cur_ksize),
    .wr_data(wr_data), .key_wr(key_wr), .ksize_wr(ksize_wr), .dsize_wr(dsize_wr),
    .mode_wr(mode_wr), .iv_wr(iv_wr), .iv_rd(iv_rd), .int_fault(int_fault),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .status(status), .halt(halt),
    .err_irq(err_irq)
  );

  function automatic logic [63:0] mk_odd(input logic [63:0] d);
    logic [63:0] r = d;
    for (int i = 0; i < 8; i++) r[8*i] = ~^d[8*i+1 +: 7];
    return r;
  endfunction

  function automatic logic [63:0] mk_bad(input logic [63:0] d, input int which);
    logic [63:0] r = mk_odd(d);
    r[8*(which % 8)] = ~r[8*(which % 8)];
    return r;
  endfunction

  function automatic logic all_odd(input logic [63:0] d);
    logic ok = 1'b1;
    for (int i = 0; i < 8; i++) ok &= ^d[8*i +: 8];
    return ok;
  endfunction

  function automatic logic [4:0] model_det();
    logic [4:0] d = '0;
    logic en2 = cur_tdes && (cur_ksize == 8'd16 || cur_ksize == 8'd24);
    logic en3 = cur_tdes && (cur_ksize == 8'd24);
    logic [7:0] ns = wr_data[7:0];
    d[4] = !all_odd(wr_data) && (key_wr[0] || (key_wr[1] && en2) || (key_wr[2] && en3));
    d[0] = ksize_wr && !(ns == 8'd8 || ns == 8'd16 || ns == 8'd24);
    d[2] = busy && iv_rd;
    d[1] = busy && (|key_wr || ksize_wr || dsize_wr || mode_wr || iv_wr);
    return d;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    key_wr = '0; ksize_wr = 0; dsize_wr = 0; mode_wr = 0; iv_wr = 0; iv_rd = 0;
    int_fault = 0; ctrl_wr = 0; ctrl_wdata = '0;
  endtask

  // inputs are set after a falling edge; one rising edge is then checked
  task automatic tick(input string tag);
    logic [4:0] d, eff, clr, nxt;
    logic       nh;
    d    = model_det();
    eff  = ctrl_wr ? ctrl_wdata[50:54] : exp_mask;
    clr  = ctrl_wr ? ctrl_wdata[50:54] : 5'b0;
    d[3] = int_fault | (|(d & 5'b10111 & ~eff));
    nxt  = (exp_st & ~clr) | (d & ~eff);
    nh   = |exp_st;
    if (ctrl_wr) exp_mask = ctrl_wdata[50:54];
    @(posedge clk); #1;
    exp_st = nxt; exp_halt = nh;
    check(tag, status, {50'b0, exp_st, 9'b0});
    check({tag, " halt"}, {63'b0, halt}, {63'b0, exp_halt});
    check({tag, " irq"}, {63'b0, err_irq}, {63'b0, exp_halt});
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic clear_all(input string tag);
    ctrl_wr = 1; ctrl_wdata = '0; ctrl_wdata[50:54] = 5'b11111; tick(tag);
    ctrl_wr = 1; ctrl_wdata = '0; tick(tag);
    tick(tag);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; busy = 0; cur_tdes = 0; cur_ksize = 8'd8; wr_data = '0;
    clear_strobes();
    exp_st = '0; exp_mask = '0; exp_halt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R10
    check("R10 reset status", status, 64'b0);
    check("R9 reset halt", {63'b0, halt}, 64'b0);

    // R1 key register 1
    wr_data = mk_odd(64'h0123456789abcdef); key_wr = 3'b001; tick("R1 good parity");
    wr_data = mk_bad(64'h0123456789abcdef, 3); key_wr = 3'b001; tick("R1 bad parity");
    tick("R9 halt follows");
    clear_all("R8 clear");

    // R2 later key registers
    cur_tdes = 0; cur_ksize = 8'd24;
    wr_data = mk_bad(64'h55, 1); key_wr = 3'b010; tick("R2 key2 single DES");
    wr_data = mk_bad(64'h55, 2); key_wr = 3'b100; tick("R2 key3 single DES");
    cur_tdes = 1; cur_ksize = 8'd8;
    wr_data = mk_bad(64'h77, 0); key_wr = 3'b010; tick("R2 key2 size 8");
    cur_ksize = 8'd16;
    wr_data = mk_bad(64'h77, 5); key_wr = 3'b100; tick("R2 key3 size 16");
    wr_data = mk_bad(64'h77, 6); key_wr = 3'b010; tick("R2 key2 size 16");
    clear_all("R8 clear");
    cur_ksize = 8'd24;
    wr_data = mk_bad(64'h99, 7); key_wr = 3'b100; tick("R2 key3 size 24");
    clear_all("R8 clear");

    // R3 key size values
    wr_data = 64'd24; ksize_wr = 1; tick("R3 size 24 ok");
    wr_data = 64'd8;  ksize_wr = 1; tick("R3 size 8 ok");
    wr_data = 64'd12; ksize_wr = 1; tick("R3 size 12");
    clear_all("R8 clear");

    // R4 / R5 busy access
    iv_rd = 1; tick("R4 idle read");
    busy = 1; iv_rd = 1; tick("R4 busy read");
    clear_all("R8 clear");
    iv_wr = 1; tick("R5 busy iv write");
    clear_all("R8 clear");
    dsize_wr = 1; tick("R5 busy data size write");
    tick("R8 sticky hold");
    clear_all("R8 clear");

    // R6 / R7 masking
    ctrl_wr = 1; ctrl_wdata[53] = 1; tick("R6 mask context");
    mode_wr = 1; tick("R6 masked context write");
    ctrl_wr = 1; ctrl_wdata[51] = 1; mode_wr = 1; iv_rd = 1; tick("R7 masked internal");
    clear_all("R8 clear");
    busy = 0;
    int_fault = 1; tick("R7 internal fault");
    clear_all("R8 clear");

    // R11 several errors together
    busy = 1; cur_tdes = 1; cur_ksize = 8'd24;
    wr_data = mk_bad(64'h1f, 4); key_wr = 3'b100; ksize_wr = 1; iv_rd = 1;
    tick("R11 simultaneous");
    clear_all("R8 clear");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int sel;
      busy     = $urandom_range(0, 1);
      cur_tdes = $urandom_range(0, 1);
      sel = $urandom_range(0, 3);
      cur_ksize = (sel == 0) ? 8'd8 : (sel == 1) ? 8'd16 : (sel == 2) ? 8'd24 : 8'($urandom);
      wr_data = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) wr_data = mk_odd(wr_data);
      if ($urandom_range(0, 1) == 0) wr_data[7:0] = 8'(8 * $urandom_range(0, 4));
      key_wr    = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
      ksize_wr  = ($urandom_range(0, 7) == 0);
      dsize_wr  = ($urandom_range(0, 15) == 0);
      mode_wr   = ($urandom_range(0, 15) == 0);
      iv_wr     = ($urandom_range(0, 15) == 0);
      iv_rd     = ($urandom_range(0, 7) == 0);
      int_fault = ($urandom_range(0, 31) == 0);
      ctrl_wr   = ($urandom_range(0, 5) == 0);
      ctrl_wdata = '0;
      if (ctrl_wr) ctrl_wdata[50:54] = 5'($urandom);
      tick("R11 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule